// File: doc/BRIEF.md
# Parallel Response Signature Compactor

This block folds a wide test response into a short signature. On every enabled clock the N-stage shift register advances one step of a modular (internal-XOR) LFSR, and each of the N response bits is XORed into the input of its own stage. One register thus compacts all outputs of a circuit under test at once, instead of one serial LFSR per output. Because the update is linear, the final signature is the XOR of the signatures that each response bit stream would leave on its own.

Before a test the register is cleared to zero or loaded with a seed. During the test the enable gates each compaction step. After the test the signature is compared with a golden value supplied on a port, and a match flag reports agreement. The feedback taps are a parameter. Bit 0 of that parameter stands for the constant term and is always taken as 1.

Top module: `misr_compactor`

## Requirements
- R1: A synchronous active-high reset sets the signature to all zeros on the next clock edge.
- R2: A high clear input zeroes the signature on the next edge and takes priority over seed load and enable.
- R3: With clear low, a high seed load copies the seed input into the signature on the next edge and takes priority over enable.
- R4: With clear, seed load and enable all low, the signature holds its value and the response inputs have no effect.
- R5: On an enabled step, stage 0 (signature bit 0) takes the old value of the last stage XOR response bit 0.
- R6: On an enabled step, stage i (i ≥ 1) takes the old stage i-1, XOR the old last stage when POLY bit i is 1, XOR response bit i.
- R7: From a zero start, the signature of a combined response equals the XOR of the signatures of each response bit stream applied alone.
- R8: The match output is high exactly when the signature equals the golden input, in the same cycle and without a register.
- R9: With WIDTH = 3 and POLY = 3'b011 (taps h1 = 1, h2 = 0), the register seeded with 3'b001 and fed zero responses returns to 3'b001 after exactly 7 steps, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Zero the signature on the next edge |
| seed_load_i | input | 1 | Load seed_i on the next edge |
| seed_i | input | WIDTH | Seed value |
| enable_i | input | 1 | Perform one compaction step |
| resp_i | input | WIDTH | Response word, bit i feeds stage i |
| golden_i | input | WIDTH | Expected good-machine signature |
| sig_o | output | WIDTH | Current signature, bit i is stage i |
| match_o | output | 1 | High when sig_o equals golden_i |

## Verification
The assertions assume the control inputs are known, settled values at every clock edge. They also assume that simultaneous requests resolve by the fixed priority clear, then seed, then enable, so each property names only the highest active request. The stimulus changes inputs only on the falling edge. It deliberately raises several controls together to test the priority, and it holds the response word at values that would alter the state while enable is low. The reference three-stage configuration lets the expected signatures be written out from the stage equations.

// File: rtl/misr_pkg.sv
package misr_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_CLEAR = 2'd1,
        OP_SEED  = 2'd2,
        OP_SHIFT = 2'd3
    } misr_op_e;

    // Fixed priority: clear, then seed, then compaction step.
    function automatic misr_op_e decode_op(input logic clr,
                                           input logic seed,
                                           input logic en);
        if (clr)       return OP_CLEAR;
        else if (seed) return OP_SEED;
        else if (en)   return OP_SHIFT;
        else           return OP_HOLD;
    endfunction

endpackage

// File: rtl/misr_ctrl.sv
module misr_ctrl
    import misr_pkg::*;
(
    input  logic     clear_i,
    input  logic     seed_load_i,
    input  logic     enable_i,
    output misr_op_e op_o
);
    always_comb op_o = decode_op(clear_i, seed_load_i, enable_i);
endmodule

// File: rtl/misr_step.sv
module misr_step #(
    parameter int unsigned       WIDTH = 16,
    parameter logic [WIDTH-1:0]  POLY  = 16'h1021
) (
    input  logic [WIDTH-1:0] state_i,
    input  logic [WIDTH-1:0] resp_i,
    output logic [WIDTH-1:0] next_o
);
    localparam int unsigned LAST = WIDTH - 1;

    logic fb;
    assign fb = state_i[LAST];

    // Stage 0 always takes the feedback (constant term of the polynomial).
    assign next_o[0] = fb ^ resp_i[0];

    for (genvar i = 1; i < WIDTH; i++) begin : g_stage
        if (POLY[i]) begin : g_tap
            assign next_o[i] = state_i[i-1] ^ fb ^ resp_i[i];
        end else begin : g_plain
            assign next_o[i] = state_i[i-1] ^ resp_i[i];
        end
    end
endmodule

// File: rtl/misr_state_reg.sv
module misr_state_reg
    import misr_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  misr_op_e         op_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic [WIDTH-1:0] next_i,
    input  logic [WIDTH-1:0] resp_i,
    output logic [WIDTH-1:0] state_o
);
    localparam int unsigned LAST = WIDTH - 1;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_o <= '0;
        end else begin
            unique case (op_i)
                OP_CLEAR: state_o <= '0;
                OP_SEED:  state_o <= seed_i;
                OP_SHIFT: state_o <= next_i;
                default:  state_o <= state_o;
            endcase
        end
    end

    p_clear_zero_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_CLEAR) |=> (state_o == '0));

    p_seed_load_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_SEED) |=> (state_o == $past(seed_i)));

    p_hold_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_HOLD) |=> $stable(state_o));

    p_stage0_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (op_i == OP_SHIFT) |=> (state_o[0] == ($past(state_o[LAST]) ^ $past(resp_i[0]))));
endmodule

// File: rtl/misr_match.sv
module misr_match #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] sig_i,
    input  logic [WIDTH-1:0] golden_i,
    output logic             match_o
);
    logic [WIDTH-1:0] diff;
    assign diff    = sig_i ^ golden_i;
    assign match_o = (diff == '0);

    always_comb begin
        p_match_r8: assert (match_o == ($countones(diff) == 0));
    end
endmodule

// File: rtl/misr_compactor.sv
module misr_compactor
    import misr_pkg::*;
#(
    parameter int unsigned      WIDTH = 16,
    parameter logic [WIDTH-1:0] POLY  = 16'h1021
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clear_i,
    input  logic             seed_load_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic             enable_i,
    input  logic [WIDTH-1:0] resp_i,
    input  logic [WIDTH-1:0] golden_i,
    output logic [WIDTH-1:0] sig_o,
    output logic             match_o
);
    misr_op_e         op;
    logic [WIDTH-1:0] next_state;

    misr_ctrl u_ctrl (
        .clear_i     (clear_i),
        .seed_load_i (seed_load_i),
        .enable_i    (enable_i),
        .op_o        (op)
    );

    misr_step #(.WIDTH(WIDTH), .POLY(POLY)) u_step (
        .state_i (sig_o),
        .resp_i  (resp_i),
        .next_o  (next_state)
    );

    misr_state_reg #(.WIDTH(WIDTH)) u_reg (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .op_i    (op),
        .seed_i  (seed_i),
        .next_i  (next_state),
        .resp_i  (resp_i),
        .state_o (sig_o)
    );

    misr_match #(.WIDTH(WIDTH)) u_match (
        .sig_i    (sig_o),
        .golden_i (golden_i),
        .match_o  (match_o)
    );

    p_reset_zero_r1: assert property (@(posedge clk_i)
        rst_i |=> (sig_o == '0));
endmodule

// File: tb/misr_compactor_tb_top.sv
module misr_compactor_tb_top;
    localparam int  W        = 3;
    localparam time CLK_PER  = 10;
    localparam int  NVEC     = 8;

    // {enable, resp[2:0], expected sig[2:0]} for POLY = 3'b011, starting from 0
    localparam logic [6:0] VEC [NVEC] = '{
        {1'b1, 3'b001, 3'b001},
        {1'b1, 3'b000, 3'b010},
        {1'b1, 3'b000, 3'b100},
        {1'b1, 3'b000, 3'b011},
        {1'b1, 3'b110, 3'b000},
        {1'b0, 3'b111, 3'b000},
        {1'b1, 3'b101, 3'b101},
        {1'b1, 3'b010, 3'b011}
    };

    logic         clk = 1'b0;
    logic         rst, clear, seed_load, enable;
    logic [W-1:0] seed, resp, golden, sig;
    logic         match;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PER/2) clk = ~clk;

    misr_compactor #(.WIDTH(W), .POLY(3'b011)) dut_i (
        .clk_i(clk), .rst_i(rst), .clear_i(clear), .seed_load_i(seed_load),
        .seed_i(seed), .enable_i(enable), .resp_i(resp), .golden_i(golden),
        .sig_o(sig), .match_o(match)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input logic c, input logic s, input logic [W-1:0] sv,
                         input logic e, input logic [W-1:0] r);
        @(negedge clk);
        clear = c; seed_load = s; seed = sv; enable = e; resp = r;
        @(posedge clk);
        #1;
    endtask

    task automatic run_seq(input logic [W-1:0] r0, input logic [W-1:0] r1,
                           input logic [W-1:0] r2, input logic [W-1:0] r3,
                           output logic [W-1:0] res);
        drive(1'b1, 1'b0, '0, 1'b0, '0);
        drive(1'b0, 1'b0, '0, 1'b1, r0);
        drive(1'b0, 1'b0, '0, 1'b1, r1);
        drive(1'b0, 1'b0, '0, 1'b1, r2);
        drive(1'b0, 1'b0, '0, 1'b1, r3);
        res = sig;
    endtask

    initial begin
        #(CLK_PER * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] sa, sb, sc, sall;
        bit early;
        rst = 1'b1; clear = 0; seed_load = 0; seed = '0; enable = 0; resp = '0; golden = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", sig, 3'b000);
        @(negedge clk); rst = 1'b0;

        // R5 R6 R4: table of compaction steps
        for (int k = 0; k < NVEC; k++) begin
            drive(1'b0, 1'b0, '0, VEC[k][6], VEC[k][5:3]);
            check($sformatf("R5/R6/R4 vec %0d", k), sig, VEC[k][2:0]);
        end

        // R2 clear beats seed and enable
        drive(1'b1, 1'b1, 3'b101, 1'b1, 3'b111);
        check("R2 clear priority", sig, 3'b000);

        // R3 seed load
        drive(1'b0, 1'b1, 3'b101, 1'b0, 3'b000);
        check("R3 seed", sig, 3'b101);
        drive(1'b0, 1'b1, 3'b110, 1'b1, 3'b111);
        check("R3 seed over enable", sig, 3'b110);

        // R4 hold with busy response
        drive(1'b0, 1'b0, '0, 1'b0, 3'b111);
        check("R4 hold", sig, 3'b110);
        drive(1'b0, 1'b0, '0, 1'b0, 3'b001);
        check("R4 hold again", sig, 3'b110);

        // R8 match, combinational
        @(negedge clk); golden = 3'b110; #1;
        check("R8 match high", {2'b00, match}, 3'b001);
        golden = 3'b111; #1;
        check("R8 match low", {2'b00, match}, 3'b000);

        // R7 superposition: each bit stream alone, then together
        run_seq(3'b001, 3'b000, 3'b001, 3'b001, sa);
        run_seq(3'b000, 3'b010, 3'b010, 3'b000, sb);
        run_seq(3'b100, 3'b100, 3'b000, 3'b000, sc);
        run_seq(3'b101, 3'b110, 3'b011, 3'b001, sall);
        check("R7 superposition", sall, sa ^ sb ^ sc);

        // R9 period of the reference configuration
        drive(1'b0, 1'b1, 3'b001, 1'b0, '0);
        early = 0;
        for (int k = 1; k < 7; k++) begin
            drive(1'b0, 1'b0, '0, 1'b1, '0);
            if (sig == 3'b001) early = 1;
        end
        check("R9 no early return", {2'b00, early}, 3'b000);
        drive(1'b0, 1'b0, '0, 1'b1, '0);
        check("R9 period 7", sig, 3'b001);

        // R1 reset mid-run
        drive(1'b0, 1'b1, 3'b111, 1'b0, '0);
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        check("R1 reset mid-run", sig, 3'b000);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule